// File: doc/BRIEF.md
# Early Transmit Underrun Guard

This block lets a frame start leaving the transmit buffer before the host has finished writing it. One DMA engine reads the frame out of buffer RAM toward the MAC while a second engine may still be filling the same frame from the host. The guard watches both byte pointers. If the reader reaches the byte the writer has not yet written, the guard commands the reader to halt. It also raises an underrun flag in the transmit status and a transmit-error flag in the interrupt status. An interrupt request follows only if the host has unmasked transmit errors.

The pointers are compared as offsets from the frame start address, modulo the buffer size of 2^AW bytes, so a frame that wraps past the end of the buffer is handled correctly. Once the writer reports the frame complete, no comparison is made for the rest of that frame. Each new transmit command latches a fresh frame start address and withdraws any pending halt. Both status flags are sticky and are cleared by the host writing a 1 to them. There is no streaming data path: every pin is a plain level or strobe sampled on the rising clock edge.

Top module: `etu_guard`

## Requirements
- R1: During and right after reset, `ldma_stop`, `tsr_underrun`, `isr_txerr` and `irq` are all 0.
- R2: An underrun trips when all of these hold in a cycle: `cfg_early_tx_en`=1, `ldma_active`=1, `rdma_busy`=1, `tx_start`=0, the frame not yet reported complete, and ((`ldma_rd_ptr`-base) mod 2^AW) >= ((`rdma_wr_ptr`-base) mod 2^AW). Here base is the `tx_frame_base` latched at the last `tx_start`. On the next clock edge, `ldma_stop`, `tsr_underrun` and `isr_txerr` all become 1.
- R3: With `cfg_early_tx_en`=0, no pointer relation ever sets `ldma_stop` or either status flag.
- R4: `irq` equals `isr_txerr` AND `irq_mask_txerr`, with no register in between.
- R5: A cycle with `rdma_done`=1 suppresses tripping in that cycle and in every later cycle, up to the next `tx_start`.
- R6: No trip occurs while `rdma_busy`=0 or `ldma_active`=0.
- R7: Once set, `ldma_stop` stays 1 until a cycle with `tx_start`=1. After that edge it is 0. A `tx_start` cycle never trips, even when the pointers overlap.
- R8: Each status flag stays set until its write strobe (`tsr_we` / `isr_we`) arrives with a 1 on its data bit (`tsr_wbit` / `isr_wbit`). A write carrying 0 leaves the flag unchanged, and `tx_start` does not clear it. If a trip and a clearing write land in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_early_tx_en | input | 1 | Enables the overlap check |
| irq_mask_txerr | input | 1 | 1 lets the transmit-error flag drive `irq` |
| tx_start | input | 1 | New transmit command; latches the base address and clears the halt |
| tx_frame_base | input | AW | Frame start address, sampled with `tx_start` |
| ldma_rd_ptr | input | AW | Byte address the local (reading) DMA fetches next |
| ldma_active | input | 1 | Local DMA is reading the frame |
| rdma_wr_ptr | input | AW | Byte address the remote (writing) DMA fills next |
| rdma_busy | input | 1 | Remote DMA transfer in progress |
| rdma_done | input | 1 | Remote DMA reports the frame fully written |
| tsr_we | input | 1 | Write strobe for the underrun flag |
| tsr_wbit | input | 1 | Write data for the underrun flag (1 clears) |
| isr_we | input | 1 | Write strobe for the transmit-error flag |
| isr_wbit | input | 1 | Write data for the transmit-error flag (1 clears) |
| ldma_stop | output | 1 | Halt command to the local DMA |
| tsr_underrun | output | 1 | Sticky early-transmit underrun flag |
| isr_txerr | output | 1 | Sticky transmit-error flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the guard with AW=4, a 16-byte buffer. At that size, every combination of frame base, read pointer and write pointer (4096 triples) can be swept. Each triple is checked against the modular offset rule computed in the bench. This reaches every wrap case: the reader or writer on either side of the buffer end, and equal offsets. The interrupt mask alternates across the sweep. Directed sequences then cover the disable bit, the completion latch, the halt hold and release, and write-1-to-clear ordering.

// File: rtl/etu_pkg.sv
package etu_pkg;
  localparam int FLAG_UNDERRUN = 0;
  localparam int FLAG_TXERR    = 1;
  localparam int NFLAG         = 2;

  typedef logic [NFLAG-1:0] etu_flags_t;
endpackage

// File: rtl/etu_offset_cmp.sv
module etu_offset_cmp #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] rd_ptr_i,
  input  logic [AW-1:0] wr_ptr_i,
  output logic          caught_o
);
  logic [AW-1:0] rd_off;
  logic [AW-1:0] wr_off;

  // Subtraction in AW bits gives the distance along the ring modulo 2^AW.
  always_comb begin
    rd_off   = rd_ptr_i - base_i;
    wr_off   = wr_ptr_i - base_i;
    caught_o = (rd_off >= wr_off);
  end
endmodule

// File: rtl/etu_frame_ctl.sv
module etu_frame_ctl #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] frame_base_i,
  input  logic          en_i,
  input  logic          rd_active_i,
  input  logic          wr_busy_i,
  input  logic          wr_done_i,
  input  logic          caught_i,
  output logic [AW-1:0] base_o,
  output logic          trip_o,
  output logic          stop_o
);
  logic [AW-1:0] base_q;
  logic          done_q;
  logic          stop_q;

  always_comb begin
    trip_o = en_i && rd_active_i && wr_busy_i && !start_i &&
             !done_q && !wr_done_i && caught_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      done_q <= 1'b0;
      stop_q <= 1'b0;
    end else if (start_i) begin
      base_q <= frame_base_i;
      done_q <= 1'b0;
      stop_q <= 1'b0;
    end else begin
      if (wr_done_i) done_q <= 1'b1;
      if (trip_o)    stop_q <= 1'b1;
    end
  end

  assign base_o = base_q;
  assign stop_o = stop_q;

  // R7
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q && !start_i |=> stop_q);

  // R3
  stop_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_q) |-> $past(en_i));

  // R5
  no_stop_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_q) |-> !$past(done_q));
endmodule

// File: rtl/etu_status.sv
module etu_status #(
  parameter int NF = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set_i,
  input  logic [NF-1:0] we_i,
  input  logic [NF-1:0] wbit_i,
  output logic [NF-1:0] flag_o
);
  logic [NF-1:0] flag_q;

  for (genvar g = 0; g < NF; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      flag_q[g] <= 1'b0;
      else if (set_i[g])               flag_q[g] <= 1'b1;
      else if (we_i[g] && wbit_i[g])   flag_q[g] <= 1'b0;
    end

    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flag_q[g] && !(we_i[g] && wbit_i[g]) |=> flag_q[g]);

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[g] |=> flag_q[g]);
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/etu_guard.sv
module etu_guard
  import etu_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_early_tx_en,
  input  logic          irq_mask_txerr,
  input  logic          tx_start,
  input  logic [AW-1:0] tx_frame_base,
  input  logic [AW-1:0] ldma_rd_ptr,
  input  logic          ldma_active,
  input  logic [AW-1:0] rdma_wr_ptr,
  input  logic          rdma_busy,
  input  logic          rdma_done,
  input  logic          tsr_we,
  input  logic          tsr_wbit,
  input  logic          isr_we,
  input  logic          isr_wbit,
  output logic          ldma_stop,
  output logic          tsr_underrun,
  output logic          isr_txerr,
  output logic          irq
);
  logic [AW-1:0] base;
  logic          caught;
  logic          trip;
  etu_flags_t    set_v, we_v, wbit_v, flags;

  etu_offset_cmp #(.AW(AW)) u_cmp (
    .base_i   (base),
    .rd_ptr_i (ldma_rd_ptr),
    .wr_ptr_i (rdma_wr_ptr),
    .caught_o (caught)
  );

  etu_frame_ctl #(.AW(AW)) u_ctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (tx_start),
    .frame_base_i (tx_frame_base),
    .en_i         (cfg_early_tx_en),
    .rd_active_i  (ldma_active),
    .wr_busy_i    (rdma_busy),
    .wr_done_i    (rdma_done),
    .caught_i     (caught),
    .base_o       (base),
    .trip_o       (trip),
    .stop_o       (ldma_stop)
  );

  always_comb begin
    set_v  = {NFLAG{trip}};
    we_v   = '0;
    wbit_v = '0;
    we_v[FLAG_UNDERRUN]   = tsr_we;
    wbit_v[FLAG_UNDERRUN] = tsr_wbit;
    we_v[FLAG_TXERR]      = isr_we;
    wbit_v[FLAG_TXERR]    = isr_wbit;
  end

  etu_status #(.NF(NFLAG)) u_sts (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (set_v),
    .we_i   (we_v),
    .wbit_i (wbit_v),
    .flag_o (flags)
  );

  assign tsr_underrun = flags[FLAG_UNDERRUN];
  assign isr_txerr    = flags[FLAG_TXERR];
  assign irq          = isr_txerr && irq_mask_txerr;

  // R2
  stop_flags_together_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ldma_stop) |-> tsr_underrun && isr_txerr);

  // R6
  stop_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ldma_stop) |-> $past(rdma_busy) && $past(ldma_active));
endmodule

// File: tb/etu_guard_test.sv
module etu_guard_test;
  localparam int AW = 4;
  localparam int SZ = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 0, mask = 0, start = 0, rd_act = 0, busy = 0, done = 0;
  logic tsr_we = 0, tsr_wbit = 0, isr_we = 0, isr_wbit = 0;
  logic [AW-1:0] base = '0, rd = '0, wr = '0;
  logic stop, und, txerr, irq;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  etu_guard #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_early_tx_en(en), .irq_mask_txerr(mask),
    .tx_start(start), .tx_frame_base(base), .ldma_rd_ptr(rd), .ldma_active(rd_act),
    .rdma_wr_ptr(wr), .rdma_busy(busy), .rdma_done(done),
    .tsr_we(tsr_we), .tsr_wbit(tsr_wbit), .isr_we(isr_we), .isr_wbit(isr_wbit),
    .ldma_stop(stop), .tsr_underrun(und), .isr_txerr(txerr), .irq(irq)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // new frame at base b, status cleared in the same cycle
  task automatic new_frame(input logic [AW-1:0] b);
    start = 1; base = b; rd_act = 0; tsr_we = 1; tsr_wbit = 1; isr_we = 1; isr_wbit = 1;
    step();
    start = 0; tsr_we = 0; tsr_wbit = 0; isr_we = 0; isr_wbit = 0;
  endtask

  initial begin
    #(20 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 stop", stop, 1'b0); chk("R1 und", und, 1'b0);
    chk("R1 txerr", txerr, 1'b0); chk("R1 irq", irq, 1'b0);
    rst_n = 1;
    step();
    chk("R1 stop after release", stop, 1'b0);

    // R2/R4 exhaustive sweep of base, read and write pointers
    en = 1; busy = 1;
    for (int b = 0; b < SZ; b++)
      for (int r = 0; r < SZ; r++)
        for (int w = 0; w < SZ; w++) begin
          logic exp;
          mask = logic'((b + r + w) & 1);
          new_frame(AW'(b));
          rd = AW'(r); wr = AW'(w); rd_act = 1;
          exp = (((r - b) & (SZ - 1)) >= ((w - b) & (SZ - 1)));
          step();
          chk("R2 stop", stop, exp);
          chk("R2 underrun", und, exp);
          chk("R2 txerr", txerr, exp);
          chk("R4 irq", irq, exp & mask);
          rd_act = 0;
        end

    // R3 disabled check
    en = 0; mask = 1;
    new_frame(4'd3);
    rd = 4'd5; wr = 4'd5; rd_act = 1;
    step();
    chk("R3 stop", stop, 1'b0); chk("R3 und", und, 1'b0); chk("R3 irq", irq, 1'b0);
    en = 1;

    // R6 remote idle or local idle
    new_frame(4'd0);
    busy = 0; rd = 4'd9; wr = 4'd2; rd_act = 1;
    step();
    chk("R6 remote idle", stop, 1'b0);
    busy = 1; rd_act = 0;
    step();
    chk("R6 local idle", stop, 1'b0);

    // R5 completion suppresses until next start
    done = 1; step(); done = 0;
    rd_act = 1; rd = 4'd12; wr = 4'd1;
    step(); step();
    chk("R5 suppressed", stop, 1'b0); chk("R5 no flag", und, 1'b0);
    rd_act = 0;
    new_frame(4'd0);
    rd_act = 1;
    step();
    chk("R5 rearmed", stop, 1'b1);

    // R7 stop held, start clears it, start cycle never trips
    rd_act = 0;
    step(); step();
    chk("R7 held", stop, 1'b1);
    start = 1; rd_act = 1;
    step();
    start = 0; rd_act = 0;
    chk("R7 start clears", stop, 1'b0);
    // R8 flags survive tx_start, write of 0 ignored, write of 1 clears
    chk("R8 und sticky", und, 1'b1);
    chk("R8 txerr sticky", txerr, 1'b1);
    tsr_we = 1; tsr_wbit = 0; isr_we = 1; isr_wbit = 0;
    step();
    chk("R8 zero write und", und, 1'b1);
    chk("R8 zero write txerr", txerr, 1'b1);
    tsr_wbit = 1; isr_wbit = 1;
    step();
    tsr_we = 0; isr_we = 0; tsr_wbit = 0; isr_wbit = 0;
    chk("R8 clear und", und, 1'b0);
    chk("R8 clear txerr", txerr, 1'b0);
    chk("R4 irq after clear", irq, 1'b0);

    // R8 set wins over clear in same cycle
    new_frame(4'd14);
    rd = 4'd1; wr = 4'd0; rd_act = 1;
    tsr_we = 1; tsr_wbit = 1; isr_we = 1; isr_wbit = 1;
    step();
    tsr_we = 0; isr_we = 0; rd_act = 0;
    chk("R8 set wins und", und, 1'b1);
    chk("R8 set wins txerr", txerr, 1'b1);
    mask = 0;
    #1 chk("R4 masked", irq, 1'b0);
    mask = 1;
    #1 chk("R4 unmasked", irq, 1'b1);

    finish_run();
  end
endmodule